// File: doc/BRIEF.md
# Bloom Filter Packet Header Validator

This block screens each packet header as it streams past, one 64-bit word per clock cycle, framed by start-of-packet and end-of-packet markers and qualified by a valid strobe. It checks the frame type, rejects packets whose hop limit has run out, and counts the set bits of the 256-bit Bloom filter carried in the header. A filter with too many bits set would match nearly every link, so such packets are refused.

The ones count is built up beat by beat while the four filter words go by, so no header has to be buffered. One cycle after the last filter word, the block gives a single verdict pulse. At the same time it passes on a 4-bit candidate output-port vector from the link-matching logic: unchanged if the packet passes, and forced to all zeros if it is dropped. A packet that ends before its filter is complete gets a drop verdict.

Top module: `hv_header_validator`

## Requirements
- R1: After reset, `verdict_valid`, `verdict_pass` and `fwd_ports` are all zero.
- R2: Beat positions are counted from the beat that carries `in_sop` (word 0). Word 1 holds the frame type in bits [31:16] and the hop limit in bits [7:0]. Words 2 to 5 hold the filter, most significant word first. A complete packet gives exactly one `verdict_valid` pulse, one cycle after the clock edge that accepts word 5.
- R3: A frame type other than 0xACDC gives a drop verdict.
- R4: A hop limit of zero gives a drop verdict. Any nonzero hop limit is accepted.
- R5: The number of ones across the 256 filter bits is compared with `MAX_ONES` (default 40). A count equal to the limit passes, and a count above it drops.
- R6: An all-zero `in_ports` value, sampled on the word-5 beat, gives a drop verdict.
- R7: On a pass verdict, `fwd_ports` equals the `in_ports` value sampled on the word-5 beat. On a drop verdict, `fwd_ports` is zero.
- R8: While `verdict_valid` is low, `verdict_pass` and `fwd_ports` are zero.
- R9: A packet whose `in_eop` comes on word 0 to 4 gives one drop verdict, in the cycle after that beat.
- R10: Cycles with `in_valid` low do not advance the beat position. Words after word 5 of the same packet produce no further verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Data word valid this cycle |
| in_sop | input | 1 | First word of a packet |
| in_eop | input | 1 | Last word of a packet |
| in_data | input | 64 | Packet data word |
| in_ports | input | 4 | Candidate output ports, sampled on word 5 |
| verdict_valid | output | 1 | One-cycle verdict strobe |
| verdict_pass | output | 1 | 1 = forward, 0 = drop |
| fwd_ports | output | 4 | Port set to forward on, zero on drop |

## Verification
The hardest case to reach is the ones-count boundary: a packet whose filter has exactly the limit or one more bit set, while every other check passes and the filter words are split up by idle cycles. The bench builds each filter by setting randomly chosen distinct bits until a requested count is reached. This lets directed packets hit the limit, the limit plus one, zero and all 256 bits. Random bubbles and truncation points are mixed in so that the accumulation is also exercised with gaps and with early ends.

// File: rtl/hv_pkg.sv
package hv_pkg;

    localparam int WORD_W  = 64;
    localparam int POP_W   = $clog2(WORD_W + 1);
    localparam int HDR_IDX = 1;
    localparam int FLT_IDX = 2;

    typedef struct packed {
        logic type_ok;
        logic ttl_ok;
    } hdr_flags_t;

    typedef enum logic [1:0] {
        VERD_NONE,
        VERD_FULL,
        VERD_SHORT
    } verd_kind_t;

    function automatic logic [POP_W-1:0] word_ones(input logic [WORD_W-1:0] w);
        logic [POP_W-1:0] n;
        n = '0;
        for (int i = 0; i < WORD_W; i++) begin
            n = n + POP_W'(w[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/hv_beat_tracker.sv
module hv_beat_tracker
    import hv_pkg::*;
#(
    parameter int FILT_WORDS = 4,
    localparam int LAST_IDX = FLT_IDX + FILT_WORDS - 1,
    localparam int IDX_W = $clog2(LAST_IDX + 2)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic             in_eop,
    output logic             beat_fire,
    output logic [IDX_W-1:0] beat_idx,
    output verd_kind_t       verd_kind
);

    logic [IDX_W-1:0] idx_q;
    logic             active_q;

    always_comb begin
        beat_idx  = in_sop ? '0 : idx_q;
        beat_fire = in_valid && (in_sop || active_q);
        verd_kind = VERD_NONE;
        if (beat_fire && beat_idx == IDX_W'(LAST_IDX)) begin
            verd_kind = VERD_FULL;
        end else if (beat_fire && in_eop && beat_idx < IDX_W'(LAST_IDX)) begin
            verd_kind = VERD_SHORT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q    <= '0;
            active_q <= 1'b0;
        end else if (beat_fire) begin
            active_q <= !in_eop;
            if (beat_idx <= IDX_W'(LAST_IDX)) begin
                idx_q <= beat_idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/hv_field_check.sv
module hv_field_check
    import hv_pkg::*;
#(
    parameter int           IDX_W = 3,
    parameter logic [15:0]  FRAME_TYPE = 16'hACDC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              beat_fire,
    input  logic [IDX_W-1:0]  beat_idx,
    input  logic [WORD_W-1:0] in_data,
    output hdr_flags_t        flags
);

    hdr_flags_t flags_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else if (beat_fire && beat_idx == '0) begin
            flags_q <= '0;
        end else if (beat_fire && beat_idx == IDX_W'(HDR_IDX)) begin
            flags_q.type_ok <= (in_data[31:16] == FRAME_TYPE);
            flags_q.ttl_ok  <= (in_data[7:0] != 8'd0);
        end
    end

    assign flags = flags_q;

endmodule

// File: rtl/hv_ones_accum.sv
module hv_ones_accum
    import hv_pkg::*;
#(
    parameter int FILT_WORDS = 4,
    parameter int IDX_W = 3,
    localparam int CNT_W = $clog2(WORD_W * FILT_WORDS + 1),
    localparam int LAST_IDX = FLT_IDX + FILT_WORDS - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              beat_fire,
    input  logic [IDX_W-1:0]  beat_idx,
    input  logic [WORD_W-1:0] in_data,
    output logic [CNT_W-1:0]  total_now
);

    logic [CNT_W-1:0] acc_q;
    logic [CNT_W-1:0] base;
    logic             in_filter;

    always_comb begin
        in_filter = (beat_idx >= IDX_W'(FLT_IDX)) && (beat_idx <= IDX_W'(LAST_IDX));
        base      = (beat_idx == IDX_W'(FLT_IDX)) ? '0 : acc_q;
        total_now = base + CNT_W'(word_ones(in_data));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (beat_fire && in_filter) begin
            acc_q <= total_now;
        end
    end

endmodule

// File: rtl/hv_header_validator.sv
module hv_header_validator
    import hv_pkg::*;
#(
    parameter int          PORTS      = 4,
    parameter int          FILT_WORDS = 4,
    parameter int          MAX_ONES   = 40,
    parameter logic [15:0] FRAME_TYPE = 16'hACDC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [63:0]       in_data,
    input  logic [PORTS-1:0]  in_ports,
    output logic              verdict_valid,
    output logic              verdict_pass,
    output logic [PORTS-1:0]  fwd_ports
);

    localparam int LAST_IDX = FLT_IDX + FILT_WORDS - 1;
    localparam int IDX_W    = $clog2(LAST_IDX + 2);
    localparam int CNT_W    = $clog2(WORD_W * FILT_WORDS + 1);

    logic             beat_fire;
    logic [IDX_W-1:0] beat_idx;
    verd_kind_t       verd_kind;
    hdr_flags_t       flags;
    logic [CNT_W-1:0] total_now;
    logic             ones_ok;
    logic             pass_now;

    hv_beat_tracker #(.FILT_WORDS(FILT_WORDS)) u_track (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sop    (in_sop),
        .in_eop    (in_eop),
        .beat_fire (beat_fire),
        .beat_idx  (beat_idx),
        .verd_kind (verd_kind)
    );

    hv_field_check #(.IDX_W(IDX_W), .FRAME_TYPE(FRAME_TYPE)) u_fields (
        .clk       (clk),
        .rst       (rst),
        .beat_fire (beat_fire),
        .beat_idx  (beat_idx),
        .in_data   (in_data),
        .flags     (flags)
    );

    hv_ones_accum #(.FILT_WORDS(FILT_WORDS), .IDX_W(IDX_W)) u_ones (
        .clk       (clk),
        .rst       (rst),
        .beat_fire (beat_fire),
        .beat_idx  (beat_idx),
        .in_data   (in_data),
        .total_now (total_now)
    );

    always_comb begin
        ones_ok  = ({1'b0, total_now} <= (CNT_W + 1)'(MAX_ONES));
        pass_now = flags.type_ok && flags.ttl_ok && ones_ok && (|in_ports);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            verdict_valid <= 1'b0;
            verdict_pass  <= 1'b0;
            fwd_ports     <= '0;
        end else begin
            unique case (verd_kind)
                VERD_FULL: begin
                    verdict_valid <= 1'b1;
                    verdict_pass  <= pass_now;
                    fwd_ports     <= pass_now ? in_ports : '0;
                end
                VERD_SHORT: begin
                    verdict_valid <= 1'b1;
                    verdict_pass  <= 1'b0;
                    fwd_ports     <= '0;
                end
                default: begin
                    verdict_valid <= 1'b0;
                    verdict_pass  <= 1'b0;
                    fwd_ports     <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/hv_checker.sv
module hv_checker #(
    parameter int PORTS = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [PORTS-1:0] in_ports,
    input logic             verdict_valid,
    input logic             verdict_pass,
    input logic [PORTS-1:0] fwd_ports
);

    a_r8_quiet_between: assert property (@(posedge clk) disable iff (rst)
        !verdict_valid |-> (!verdict_pass && fwd_ports == '0));

    a_r7_drop_clears: assert property (@(posedge clk) disable iff (rst)
        (verdict_valid && !verdict_pass) |-> fwd_ports == '0);

    a_r6_pass_has_port: assert property (@(posedge clk) disable iff (rst)
        (verdict_valid && verdict_pass) |-> fwd_ports != '0);

    a_r7_pass_copies: assert property (@(posedge clk) disable iff (rst)
        (verdict_valid && verdict_pass) |-> fwd_ports == $past(in_ports));

    a_r10_after_beat: assert property (@(posedge clk) disable iff (rst)
        verdict_valid |-> $past(in_valid));

endmodule

bind hv_header_validator hv_checker #(.PORTS(PORTS)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .in_valid      (in_valid),
    .in_ports      (in_ports),
    .verdict_valid (verdict_valid),
    .verdict_pass  (verdict_pass),
    .fwd_ports     (fwd_ports)
);

// File: tb/sim_hv_header_validator.sv
`timescale 1ns/1ps
module sim_hv_header_validator;

    localparam int MAXO = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_sop = 1'b0;
    logic        in_eop = 1'b0;
    logic [63:0] in_data = '0;
    logic [3:0]  in_ports = '0;
    logic        verdict_valid;
    logic        verdict_pass;
    logic [3:0]  fwd_ports;

    int n_vec = 0;
    int n_bad = 0;
    int vcnt = 0;
    int r8_bad = 0;
    logic       vpass;
    logic [3:0] vfwd;
    bit done = 0;

    always #2 clk = ~clk;

    hv_header_validator #(.MAX_ONES(MAXO)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .in_data(in_data), .in_ports(in_ports),
        .verdict_valid(verdict_valid), .verdict_pass(verdict_pass),
        .fwd_ports(fwd_ports)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (verdict_valid) begin
                vcnt  = vcnt + 1;
                vpass = verdict_pass;
                vfwd  = fwd_ports;
            end else if (verdict_pass || fwd_ports != 4'd0) begin
                r8_bad = r8_bad + 1;
            end
        end
    end

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic logic [255:0] make_filt(input int n);
        logic [255:0] f = '0;
        while ($countones(f) < n) f[$urandom % 256] = 1'b1;
        return f;
    endfunction

    function automatic logic exp_pass(input logic [15:0] ft, input logic [7:0] ttl,
                                      input logic [255:0] f, input logic [3:0] p, input int trunc);
        if (trunc < 5) return 1'b0;
        return (ft == 16'hACDC) && (ttl != 8'd0) && ($countones(f) <= MAXO) && (p != 4'd0);
    endfunction

    task automatic beat(input logic sop, input logic eop, input logic [63:0] d, input int bub);
        for (int b = 0; b < bub; b++) begin
            in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_data = $urandom;
            @(negedge clk);
        end
        in_valid = 1'b1; in_sop = sop; in_eop = eop; in_data = d;
        @(negedge clk);
    endtask

    // trunc < 5: eop on word trunc; trunc >= 5: eop on word 5 + extra
    task automatic send(input string rq, input logic [15:0] ft, input logic [7:0] ttl,
                        input logic [255:0] f, input logic [3:0] p, input int trunc,
                        input int extra, input int bubpct);
        int last;
        int start;
        logic [63:0] w;
        logic ep;
        last  = (trunc < 5) ? trunc : 5 + extra;
        start = vcnt;
        in_ports = p;
        for (int i = 0; i <= last; i++) begin
            case (i)
                0: w = {$urandom, $urandom};
                1: w = {$urandom, ft, 8'($urandom), ttl};
                2: w = f[255:192];
                3: w = f[191:128];
                4: w = f[127:64];
                5: w = f[63:0];
                default: w = {$urandom, $urandom};
            endcase
            ep = (i == last);
            beat(i == 0, ep, w, (($urandom % 100) < bubpct) ? 1 + ($urandom % 3) : 0);
        end
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_ports = '0;
        repeat (3) @(negedge clk);
        #1;
        check({rq, " verdict count"}, vcnt - start, 1);
        check({rq, " pass"}, 32'(vpass), 32'(exp_pass(ft, ttl, f, p, trunc)));
        check("R7 fwd_ports", 32'(vfwd), exp_pass(ft, ttl, f, p, trunc) ? 32'(p) : 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        check("R1 verdict_valid", 32'(verdict_valid), 0);
        check("R1 verdict_pass", 32'(verdict_pass), 0);
        check("R1 fwd_ports", 32'(fwd_ports), 0);
        rst = 1'b0;
        @(negedge clk);

        send("R2 good", 16'hACDC, 8'd9, make_filt(5), 4'b0110, 5, 0, 0);
        send("R3 bad type", 16'hACDD, 8'd9, make_filt(5), 4'b0110, 5, 0, 0);
        send("R3 swapped type", 16'hDCAC, 8'd9, make_filt(5), 4'b1111, 5, 0, 0);
        send("R4 ttl zero", 16'hACDC, 8'd0, make_filt(5), 4'b0001, 5, 0, 0);
        send("R4 ttl max", 16'hACDC, 8'd255, make_filt(5), 4'b1000, 5, 0, 0);
        send("R5 at limit", 16'hACDC, 8'd3, make_filt(MAXO), 4'b0011, 5, 0, 0);
        send("R5 over limit", 16'hACDC, 8'd3, make_filt(MAXO + 1), 4'b0011, 5, 0, 0);
        send("R5 empty filter", 16'hACDC, 8'd3, '0, 4'b0100, 5, 0, 0);
        send("R5 full filter", 16'hACDC, 8'd3, '1, 4'b0100, 5, 0, 0);
        send("R5 limit bubbles", 16'hACDC, 8'd3, make_filt(MAXO), 4'b1010, 5, 0, 90);
        send("R6 no ports", 16'hACDC, 8'd3, make_filt(7), 4'b0000, 5, 0, 0);
        for (int t = 0; t < 5; t++) begin
            send("R9 truncated", 16'hACDC, 8'd3, make_filt(7), 4'b1111, t, 0, 0);
        end
        send("R10 extra words", 16'hACDC, 8'd3, make_filt(7), 4'b0101, 5, 3, 0);
        send("R10 bubbles", 16'hACDC, 8'd3, make_filt(7), 4'b1001, 5, 1, 100);

        for (int k = 0; k < 300; k++) begin
            logic [15:0] ft;
            logic [7:0]  ttl;
            int          ones;
            int          tr;
            ft   = (($urandom % 100) < 85) ? 16'hACDC : 16'($urandom);
            ttl  = (($urandom % 100) < 10) ? 8'd0 : 8'($urandom);
            ones = (($urandom % 100) < 70) ? MAXO - 6 + ($urandom % 10) : $urandom % 257;
            tr   = (($urandom % 100) < 8) ? $urandom % 5 : 5;
            send("R2 random", ft, ttl, make_filt(ones), 4'($urandom), tr,
                 $urandom % 3, $urandom % 40);
        end

        check("R8 idle outputs", r8_bad, 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule